// File: doc/BRIEF.md
# Legacy Virtio Header Register Decoder

This block decodes the register header that a transitional virtio device exposes through its older I/O interface. Every access arrives on a simple byte-addressed bus. Each access carries a size code, and it must use the natural width of the field it targets. The header holds the following registers:

- a 32-bit device feature word
- a 32-bit driver-acknowledged feature word
- a per-queue ring location, stored as a page frame number
- queue size, queue select and queue notify fields
- a device status byte
- an interrupt status byte that clears when it is read

When MSI-X is enabled, two 16-bit vector registers sit after the fixed fields, and the device-specific area starts after them. When MSI-X is disabled, the device-specific area starts straight after the interrupt status byte.

Accesses that fall in the device-specific area are forwarded to the device through a select strobe and an offset relative to the start of that area. The read data from the device is returned on the bus. The rest of the chip receives the following from the header registers:

- the acknowledged features
- each queue's ring base address
- the vectors
- the status byte
- a notify pulse that carries the queue index

Top module: `legacyHdrDecoder`

## Requirements
- R1: After reset, the following read as 0: the driver features, the status byte, every queue page frame, every vector and the interrupt status. busRdata is 0 and notifyValid is low. The queue size field of any queue that exists reads QUEUE_MAX.
- R2: A 32-bit read (busSize=2) at byte 0 returns devFeatures. Byte 4 is a 32-bit read/write driver feature word. ackFeatures[31:0] mirrors that word, and ackFeatures[63:32] is always 0.
- R3: Byte 8 is a 32-bit read/write page frame number for the selected queue. queueBase slice q (bits q*44 upward) equals that queue's frame number shifted left by 12.
- R4: Byte 14 is the 16-bit queue select register. Byte 12 is the 16-bit read-only queue size, which reads QUEUE_MAX for a selected queue below NUM_QUEUES. When the select value is NUM_QUEUES or above, the queue size and frame number read 0, and writes to queue fields are ignored.
- R5: A 16-bit write at byte 16 raises notifyValid for exactly one cycle, on the clock after the write. notifyQueue carries the written index. A read at byte 16 returns 0.
- R6: Byte 18 is the 8-bit read/write status byte (busSize=0), and it drives devStatus.
- R7: With msixEn low, a byte read at 19 returns the accumulated interrupt bits and clears them. A bit raised on irqSet in the same cycle as that read is kept.
- R8: With msixEn high, a read at byte 19 returns 0 and clears nothing.
- R9: With msixEn high, byte 20 is the 16-bit configuration vector, which drives cfgVector. Byte 22 is the 16-bit vector of the selected queue, which drives its slice of queueVectors.
- R10: The device-specific area starts at byte 24 when msixEn is high and at byte 20 when msixEn is low. The start follows msixEn combinationally. Inside that area, devSel is high, devOffset is busAddr minus the start, and reads return devRdata.
- R11: A header access whose size or start address does not match its field exactly is ignored. Such a write changes nothing, and such a read returns 0. The size codes are: busSize 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes.
- R12: busRdata is registered. It updates on the clock edge of a busRd cycle and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msixEn | input | 1 | MSI-X enabled; moves the device-specific area |
| busAddr | input | AW | Byte address of the access |
| busSize | input | 2 | Access size: 0 for byte, 1 for 16-bit, 2 for 32-bit |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data, right-aligned; also passed to the device |
| busRdata | output | 32 | Registered read data, right-aligned |
| devFeatures | input | 32 | Feature bits 0 to 31 that the device offers |
| ackFeatures | output | 64 | Features acknowledged by the driver; upper half is 0 |
| irqSet | input | 8 | Interrupt status bits to set |
| devStatus | output | 8 | Device status byte |
| cfgVector | output | 16 | Configuration change vector |
| queueBase | output | NUM_QUEUES*44 | Ring base address of each queue |
| queueVectors | output | NUM_QUEUES*16 | Vector of each queue |
| notifyValid | output | 1 | One-cycle queue notify pulse |
| notifyQueue | output | 16 | Index of the notified queue |
| devSel | output | 1 | Access falls in the device-specific area |
| devWr | output | 1 | Write to the device-specific area |
| devRd | output | 1 | Read from the device-specific area |
| devOffset | output | AW | Offset within the device-specific area |
| devRdata | input | 32 | Read data from the device-specific area |

## Verification
The timing of each result is fixed:

- A register write takes effect at the clock edge of the write cycle. The bench drives each access at a falling edge and observes outputs at the next falling edge.
- A read result appears on busRdata one edge after the busRd cycle. The read task samples it at the falling edge that follows.
- notifyValid is checked at that same falling edge after the notify write, and again one cycle later to confirm it has dropped.
- devSel and devOffset are combinational. They are sampled while the access is still being driven, before any clock edge.

// File: rtl/legacyHdrPkg.sv
package legacyHdrPkg;
  localparam int OFS_DEVFEAT = 0;
  localparam int OFS_GSTFEAT = 4;
  localparam int OFS_QPFN    = 8;
  localparam int OFS_QSIZE   = 12;
  localparam int OFS_QSEL    = 14;
  localparam int OFS_NOTIFY  = 16;
  localparam int OFS_STATUS  = 18;
  localparam int OFS_ISR     = 19;
  localparam int OFS_CFGVEC  = 20;
  localparam int OFS_QVEC    = 22;
  localparam int DEV_BASE_PLAIN = 20;
  localparam int DEV_BASE_MSIX  = 24;
  localparam int PAGE_SHIFT = 12;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_H = 2'd1;
  localparam logic [1:0] SZ_W = 2'd2;

  typedef enum logic [3:0] {
    FLD_NONE, FLD_DEVFEAT, FLD_GSTFEAT, FLD_QPFN, FLD_QSIZE, FLD_QSEL,
    FLD_NOTIFY, FLD_STATUS, FLD_ISR, FLD_CFGVEC, FLD_QVEC, FLD_DEV
  } fld_e;

  typedef struct packed {
    logic wrGstFeat;
    logic wrQPfn;
    logic wrQSel;
    logic wrNotify;
    logic wrStatus;
    logic wrCfgVec;
    logic wrQVec;
    logic clrIsr;
    logic rdEn;
    fld_e rdFld;
  } strobe_t;
endpackage

// File: rtl/legacyHdrCtrl.sv
module legacyHdrCtrl
  import legacyHdrPkg::*;
#(
  parameter int AW = 8
) (
  input  logic          msixEn,
  input  logic [AW-1:0] busAddr,
  input  logic [1:0]    busSize,
  input  logic          busWr,
  input  logic          busRd,
  output strobe_t       stb,
  output logic          devSel,
  output logic [AW-1:0] devOffset
);
  logic [AW-1:0] devBase;
  fld_e fld;

  assign devBase = msixEn ? AW'(DEV_BASE_MSIX) : AW'(DEV_BASE_PLAIN);

  always_comb begin
    devSel    = (busRd || busWr) && (busAddr >= devBase);
    devOffset = devSel ? (busAddr - devBase) : '0;
    fld       = FLD_NONE;
    if (devSel) begin
      fld = FLD_DEV;
    end else begin
      case (busAddr)
        AW'(OFS_DEVFEAT): if (busSize == SZ_W) fld = FLD_DEVFEAT;
        AW'(OFS_GSTFEAT): if (busSize == SZ_W) fld = FLD_GSTFEAT;
        AW'(OFS_QPFN):    if (busSize == SZ_W) fld = FLD_QPFN;
        AW'(OFS_QSIZE):   if (busSize == SZ_H) fld = FLD_QSIZE;
        AW'(OFS_QSEL):    if (busSize == SZ_H) fld = FLD_QSEL;
        AW'(OFS_NOTIFY):  if (busSize == SZ_H) fld = FLD_NOTIFY;
        AW'(OFS_STATUS):  if (busSize == SZ_B) fld = FLD_STATUS;
        AW'(OFS_ISR):     if (busSize == SZ_B && !msixEn) fld = FLD_ISR;
        AW'(OFS_CFGVEC):  if (busSize == SZ_H && msixEn) fld = FLD_CFGVEC;
        AW'(OFS_QVEC):    if (busSize == SZ_H && msixEn) fld = FLD_QVEC;
        default:          fld = FLD_NONE;
      endcase
    end
  end

  always_comb begin
    stb           = '0;
    stb.rdEn      = busRd;
    stb.rdFld     = (busRd && fld != FLD_NOTIFY) ? fld : FLD_NONE;
    stb.wrGstFeat = busWr && fld == FLD_GSTFEAT;
    stb.wrQPfn    = busWr && fld == FLD_QPFN;
    stb.wrQSel    = busWr && fld == FLD_QSEL;
    stb.wrNotify  = busWr && fld == FLD_NOTIFY;
    stb.wrStatus  = busWr && fld == FLD_STATUS;
    stb.wrCfgVec  = busWr && fld == FLD_CFGVEC;
    stb.wrQVec    = busWr && fld == FLD_QVEC;
    stb.clrIsr    = busRd && fld == FLD_ISR;
  end
endmodule

// File: rtl/legacyHdrRegs.sv
module legacyHdrRegs
  import legacyHdrPkg::*;
#(
  parameter int NUM_QUEUES = 4,
  parameter int QUEUE_MAX  = 256
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [31:0]             busWdata,
  input  logic [31:0]             devFeatures,
  input  logic [7:0]              irqSet,
  input  logic [31:0]             devRdata,
  output logic [31:0]             busRdata,
  output logic [31:0]             gstFeatures,
  output logic [7:0]              devStatus,
  output logic [15:0]             cfgVector,
  output logic [NUM_QUEUES*44-1:0] queueBase,
  output logic [NUM_QUEUES*16-1:0] queueVectors,
  output logic                    notifyValid,
  output logic [15:0]             notifyQueue
);
  localparam int QW  = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1;
  localparam int QBW = 32 + PAGE_SHIFT;

  logic [15:0] qSel;
  logic        qHit;
  logic [QW-1:0] qIdx;
  logic [31:0] pfnQ [NUM_QUEUES];
  logic [15:0] qVecQ [NUM_QUEUES];
  logic [7:0]  isrQ;
  logic [31:0] rdMux;

  assign qHit = qSel < 16'(NUM_QUEUES);
  assign qIdx = qSel[QW-1:0];

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : gQueue
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pfnQ[g]  <= '0;
        qVecQ[g] <= '0;
      end else if (qHit && qIdx == QW'(g)) begin
        if (stb.wrQPfn) pfnQ[g]  <= busWdata;
        if (stb.wrQVec) qVecQ[g] <= busWdata[15:0];
      end
    end
    assign queueBase[g*QBW +: QBW]  = {pfnQ[g], {PAGE_SHIFT{1'b0}}};
    assign queueVectors[g*16 +: 16] = qVecQ[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qSel        <= '0;
      gstFeatures <= '0;
      devStatus   <= '0;
      cfgVector   <= '0;
      isrQ        <= '0;
      notifyValid <= 1'b0;
      notifyQueue <= '0;
    end else begin
      if (stb.wrQSel)    qSel        <= busWdata[15:0];
      if (stb.wrGstFeat) gstFeatures <= busWdata;
      if (stb.wrStatus)  devStatus   <= busWdata[7:0];
      if (stb.wrCfgVec)  cfgVector   <= busWdata[15:0];
      isrQ        <= (stb.clrIsr ? 8'h00 : isrQ) | irqSet;
      notifyValid <= stb.wrNotify;
      if (stb.wrNotify)  notifyQueue <= busWdata[15:0];
    end
  end

  always_comb begin
    case (stb.rdFld)
      FLD_DEVFEAT: rdMux = devFeatures;
      FLD_GSTFEAT: rdMux = gstFeatures;
      FLD_QPFN:    rdMux = qHit ? pfnQ[qIdx] : '0;
      FLD_QSIZE:   rdMux = qHit ? 32'(QUEUE_MAX) : '0;
      FLD_QSEL:    rdMux = {16'h0, qSel};
      FLD_STATUS:  rdMux = {24'h0, devStatus};
      FLD_ISR:     rdMux = {24'h0, isrQ};
      FLD_CFGVEC:  rdMux = {16'h0, cfgVector};
      FLD_QVEC:    rdMux = qHit ? {16'h0, qVecQ[qIdx]} : '0;
      FLD_DEV:     rdMux = devRdata;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)         busRdata <= '0;
    else if (stb.rdEn) busRdata <= rdMux;
  end
endmodule

// File: rtl/legacyHdrDecoder.sv
module legacyHdrDecoder
  import legacyHdrPkg::*;
#(
  parameter int AW         = 8,
  parameter int NUM_QUEUES = 4,
  parameter int QUEUE_MAX  = 256
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     msixEn,
  input  logic [AW-1:0]            busAddr,
  input  logic [1:0]               busSize,
  input  logic                     busWr,
  input  logic                     busRd,
  input  logic [31:0]              busWdata,
  output logic [31:0]              busRdata,
  input  logic [31:0]              devFeatures,
  output logic [63:0]              ackFeatures,
  input  logic [7:0]               irqSet,
  output logic [7:0]               devStatus,
  output logic [15:0]              cfgVector,
  output logic [NUM_QUEUES*44-1:0] queueBase,
  output logic [NUM_QUEUES*16-1:0] queueVectors,
  output logic                     notifyValid,
  output logic [15:0]              notifyQueue,
  output logic                     devSel,
  output logic                     devWr,
  output logic                     devRd,
  output logic [AW-1:0]            devOffset,
  input  logic [31:0]              devRdata
);
  strobe_t     stb;
  logic [31:0] gstFeatures;

  legacyHdrCtrl #(.AW(AW)) uCtrl (
    .msixEn(msixEn), .busAddr(busAddr), .busSize(busSize),
    .busWr(busWr), .busRd(busRd),
    .stb(stb), .devSel(devSel), .devOffset(devOffset)
  );

  legacyHdrRegs #(.NUM_QUEUES(NUM_QUEUES), .QUEUE_MAX(QUEUE_MAX)) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .devFeatures(devFeatures), .irqSet(irqSet), .devRdata(devRdata),
    .busRdata(busRdata), .gstFeatures(gstFeatures), .devStatus(devStatus),
    .cfgVector(cfgVector), .queueBase(queueBase), .queueVectors(queueVectors),
    .notifyValid(notifyValid), .notifyQueue(notifyQueue)
  );

  assign ackFeatures = {32'h0, gstFeatures};
  assign devWr       = devSel && busWr;
  assign devRd       = devSel && busRd;
endmodule

// File: rtl/legacyHdrChecker.sv
module legacyHdrChecker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          msixEn,
  input logic [AW-1:0] busAddr,
  input logic [1:0]    busSize,
  input logic          busWr,
  input logic          busRd,
  input logic [31:0]   busWdata,
  input logic [31:0]   busRdata,
  input logic [7:0]    irqSet,
  input logic          notifyValid,
  input logic [15:0]   notifyQueue,
  input logic          devSel
);
  logic notifyWr, isrRdPlain, isrRdMsix;
  assign notifyWr   = busWr && busAddr == AW'(16) && busSize == 2'd1;
  assign isrRdPlain = !msixEn && busRd && busAddr == AW'(19) && busSize == 2'd0 && irqSet == 8'h0;
  assign isrRdMsix  = msixEn && busRd && busAddr == AW'(19);

  // R5
  a_r5_notify_pulse: assert property (@(posedge clk) disable iff (!rstN)
    notifyWr |=> notifyValid && notifyQueue == $past(busWdata[15:0]));
  // R5
  a_r5_notify_single: assert property (@(posedge clk) disable iff (!rstN)
    !notifyWr |=> !notifyValid);
  // R7
  a_r7_isr_clear: assert property (@(posedge clk) disable iff (!rstN)
    isrRdPlain ##1 isrRdPlain |=> busRdata == 32'h0);
  // R8
  a_r8_isr_hidden: assert property (@(posedge clk) disable iff (!rstN)
    isrRdMsix |=> busRdata == 32'h0);
  // R10
  a_r10_dev_base: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) && busAddr < (msixEn ? AW'(24) : AW'(20)) |-> !devSel);
  // R11
  a_r11_width: assert property (@(posedge clk) disable iff (!rstN)
    busRd && busAddr == AW'(0) && busSize != 2'd2 |=> busRdata == 32'h0);
  // R12
  a_r12_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));
endmodule

bind legacyHdrDecoder legacyHdrChecker #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .msixEn(msixEn), .busAddr(busAddr),
  .busSize(busSize), .busWr(busWr), .busRd(busRd), .busWdata(busWdata),
  .busRdata(busRdata), .irqSet(irqSet), .notifyValid(notifyValid),
  .notifyQueue(notifyQueue), .devSel(devSel)
);

// File: tb/test_legacyHdrDecoder.sv
module test_legacyHdrDecoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NQ = 4;
  localparam int QMAX = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msixEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [1:0] busSize = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0, busRdata;
  logic [31:0] devFeatures = 32'hA5A5_1234;
  logic [63:0] ackFeatures;
  logic [7:0] irqSet = '0, devStatus;
  logic [15:0] cfgVector, notifyQueue;
  logic [NQ*44-1:0] queueBase;
  logic [NQ*16-1:0] queueVectors;
  logic notifyValid, devSel, devWr, devRd;
  logic [AW-1:0] devOffset;
  logic [31:0] devRdata;
  int total = 0, failed = 0;

  assign devRdata = 32'hDE00_0000 | 32'(devOffset);

  always #(CLK_PERIOD/2) clk = ~clk;

  legacyHdrDecoder #(.AW(AW), .NUM_QUEUES(NQ), .QUEUE_MAX(QMAX)) i_legacyHdrDecoder (
    .clk(clk), .rstN(rstN), .msixEn(msixEn), .busAddr(busAddr), .busSize(busSize),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .devFeatures(devFeatures), .ackFeatures(ackFeatures), .irqSet(irqSet),
    .devStatus(devStatus), .cfgVector(cfgVector), .queueBase(queueBase),
    .queueVectors(queueVectors), .notifyValid(notifyValid), .notifyQueue(notifyQueue),
    .devSel(devSel), .devWr(devWr), .devRd(devRd), .devOffset(devOffset),
    .devRdata(devRdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [1:0] size, input logic [31:0] data);
    @(negedge clk);
    busAddr = AW'(addr); busSize = size; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input int addr, input logic [1:0] size, output logic [31:0] data);
    @(negedge clk);
    busAddr = AW'(addr); busSize = size; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    data = busRdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 rdata", 64'(busRdata), 64'h0);
    check("R1 notifyValid", 64'(notifyValid), 64'h0);
    check("R1 ackFeatures", ackFeatures, 64'h0);
    check("R1 queueBase", 64'(queueBase[0 +: 44]), 64'h0);
    busRead(18, 2'd0, d); check("R1 status", 64'(d), 64'h0);
    busRead(12, 2'd1, d); check("R1 qsize", 64'(d), 64'(QMAX));
  endtask

  task automatic t_features;
    logic [31:0] d;
    busRead(0, 2'd2, d); check("R2 devFeatures", 64'(d), 64'hA5A5_1234);
    busWrite(4, 2'd2, 32'hFFFF_FFFF);
    check("R2 ackFeatures", ackFeatures, 64'h0000_0000_FFFF_FFFF);
    busRead(4, 2'd2, d); check("R2 readback", 64'(d), 64'hFFFF_FFFF);
  endtask

  task automatic t_queue;
    logic [31:0] d;
    busWrite(14, 2'd1, 32'd2);
    busWrite(8, 2'd2, 32'h0001_2345);
    check("R3 queueBase q2", 64'(queueBase[2*44 +: 44]), 64'h0000_0123_4500_0);
    busRead(8, 2'd2, d); check("R3 pfn readback", 64'(d), 64'h0001_2345);
    busWrite(14, 2'd1, 32'd1);
    busRead(8, 2'd2, d); check("R3 q1 pfn", 64'(d), 64'h0);
    busRead(14, 2'd1, d); check("R4 qsel readback", 64'(d), 64'd1);
    busWrite(14, 2'd1, 32'd7);
    busWrite(8, 2'd2, 32'hDEAD_BEEF);
    busRead(12, 2'd1, d); check("R4 oor qsize", 64'(d), 64'h0);
    busRead(8, 2'd2, d); check("R4 oor pfn", 64'(d), 64'h0);
    check("R4 oor no write", 64'(queueBase[3*44 +: 44]) | 64'(queueBase[1*44 +: 44]), 64'h0);
    check("R4 q2 intact", 64'(queueBase[2*44 +: 44]), 64'h0000_0123_4500_0);
  endtask

  task automatic t_notify;
    logic [31:0] d;
    busWrite(16, 2'd1, 32'd3);
    check("R5 notifyValid", 64'(notifyValid), 64'h1);
    check("R5 notifyQueue", 64'(notifyQueue), 64'd3);
    @(negedge clk);
    check("R5 single pulse", 64'(notifyValid), 64'h0);
    busRead(16, 2'd1, d); check("R5 read zero", 64'(d), 64'h0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    busWrite(18, 2'd0, 32'h0000_000F);
    check("R6 devStatus", 64'(devStatus), 64'h0F);
    busRead(18, 2'd0, d); check("R6 readback", 64'(d), 64'h0F);
  endtask

  task automatic t_isr;
    logic [31:0] d;
    msixEn = 1'b0;
    @(negedge clk); irqSet = 8'h01; @(negedge clk); irqSet = 8'h00;
    busRead(19, 2'd0, d); check("R7 isr read", 64'(d), 64'h01);
    busRead(19, 2'd0, d); check("R7 isr cleared", 64'(d), 64'h00);
    @(negedge clk); irqSet = 8'h04; @(negedge clk); irqSet = 8'h00;
    @(negedge clk);
    busAddr = AW'(19); busSize = 2'd0; busRd = 1'b1; irqSet = 8'h10;
    @(negedge clk);
    busRd = 1'b0; irqSet = 8'h00;
    check("R7 read old bits", 64'(busRdata), 64'h04);
    busRead(19, 2'd0, d); check("R7 same-cycle set kept", 64'(d), 64'h10);
    msixEn = 1'b1;
    @(negedge clk); irqSet = 8'h02; @(negedge clk); irqSet = 8'h00;
    busRead(19, 2'd0, d); check("R8 isr hidden", 64'(d), 64'h0);
    msixEn = 1'b0;
    busRead(19, 2'd0, d); check("R8 not cleared", 64'(d), 64'h02);
  endtask

  task automatic t_vectors;
    logic [31:0] d;
    msixEn = 1'b1;
    busWrite(20, 2'd1, 32'h0005);
    check("R9 cfgVector", 64'(cfgVector), 64'h5);
    busWrite(14, 2'd1, 32'd2);
    busWrite(22, 2'd1, 32'h0007);
    check("R9 queueVectors q2", 64'(queueVectors[2*16 +: 16]), 64'h7);
    busRead(22, 2'd1, d); check("R9 qvec readback", 64'(d), 64'h7);
    @(negedge clk);
    busAddr = AW'(24); busSize = 2'd2; busRd = 1'b1;
    #1;
    check("R10 msix devSel", 64'(devSel), 64'h1);
    check("R10 msix offset", 64'(devOffset), 64'h0);
    @(negedge clk); busRd = 1'b0;
    check("R10 msix devRdata", 64'(busRdata), 64'hDE00_0000);
    msixEn = 1'b0;
    @(negedge clk);
    busAddr = AW'(22); busSize = 2'd1; busRd = 1'b1;
    #1;
    check("R10 plain devSel", 64'(devSel), 64'h1);
    check("R10 plain offset", 64'(devOffset), 64'h2);
    @(negedge clk); busRd = 1'b0;
    check("R10 plain devRdata", 64'(busRdata), 64'hDE00_0002);
    busWrite(20, 2'd1, 32'h0009);
    check("R9 cfgVector untouched when off", 64'(cfgVector), 64'h5);
  endtask

  task automatic t_width;
    logic [31:0] d;
    busWrite(4, 2'd1, 32'h0000_1111);
    busRead(4, 2'd2, d); check("R11 narrow write ignored", 64'(d), 64'hFFFF_FFFF);
    busRead(0, 2'd0, d); check("R11 narrow read zero", 64'(d), 64'h0);
    busRead(5, 2'd2, d); check("R11 misaligned read zero", 64'(d), 64'h0);
    busWrite(18, 2'd1, 32'h0000_00AA);
    check("R11 status untouched", 64'(devStatus), 64'h0F);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    busRead(0, 2'd2, d);
    @(negedge clk); @(negedge clk);
    check("R12 rdata holds", 64'(busRdata), 64'hA5A5_1234);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failed++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_features();
    t_queue();
    t_notify();
    t_status();
    t_isr();
    t_vectors();
    t_width();
    t_hold();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule